// File: doc/BRIEF.md
# Real-Time-Clock Control Register with Interrupt Steering

This block holds the eight-bit control byte of a real-time clock and the logic that turns three event strobes (periodic, alarm, update-ended) into latched flags and a single active-low interrupt line. A host reaches it through a small read/write port with two locations. One location is the control byte. The other is a read-only status byte that reports the flags, and reading it clears them.

Each control bit follows its own rule for the two reset sources. The first source, `por_n`, is an asynchronous power-up indication. It loads the power-up pattern, in which only the square-wave enable is set. The second source, `rst_n`, is a synchronous functional reset pin. It clears the periodic and update-ended interrupt enables, the square-wave enable and the flags. It leaves every other bit alone.

The block also drives two outputs to other logic. The first is a square-wave output, taken from one of several divider taps that a rate code selects. The second is an update-inhibit signal for the timekeeper, which holds off the once-per-second transfer while the host loads the time.

Top module: `rtc_ctrl_irq`

## Requirements
- R1: After `por_n` is released, the control byte reads 8'h08 (only SQWE, bit 3, set), all flags are 0, `irq_n` is 1 and `upd_inhibit_o` is 0.
- R2: Control bit positions are SET=7, PIE=6, AIE=5, UIE=4, SQWE=3, DM=2, H24=1, DSE=0. A write to address 0 with `rst_n` high stores `wdata`, and a read of address 0 returns it on `rdata` one cycle after the read strobe.
- R3: A control write with bit 7 (SET) equal to 1 stores UIE (bit 4) as 0, whatever value `wdata` carries in bit 4.
- R4: While `rst_n` is low at a clock edge, PIE, UIE, SQWE and all three flags are cleared. SET, AIE, DM, H24 and DSE keep their values, and a host write in that cycle is ignored.
- R5: A pulse on `per_evt`, `alm_evt` or `upd_evt` sets its flag (`flags_o` bit 2, 1 or 0) at the next edge, whatever the enable bits are.
- R6: `irq_n` is low exactly when (PF and PIE) or (AF and AIE) or (UF and UIE).
- R7: A read of address 1 returns {IRQF, PF, AF, UF, 4'b0000}, where IRQF is the inverse of `irq_n`. It clears the flags at the same edge. An event that arrives in the read cycle is kept for the next read.
- R8: `sqw_o` follows `rate_taps[rate_sel]` one cycle later while SQWE is 1 and `rate_sel` is not 0. Otherwise it is 0.
- R9: `upd_inhibit_o` equals the SET bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-up indication, active low |
| rst_n | input | 1 | Synchronous functional reset pin, active low |
| cs | input | 1 | Host access strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 1 | 0 = control byte, 1 = status byte |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, registered |
| per_evt | input | 1 | Periodic event strobe |
| alm_evt | input | 1 | Alarm-match event strobe |
| upd_evt | input | 1 | Update-ended event strobe |
| rate_sel | input | RATE_W | Rate code for the square wave |
| rate_taps | input | 2**RATE_W | Divider tap levels |
| irq_n | output | 1 | Interrupt, active low |
| sqw_o | output | 1 | Square-wave output |
| upd_inhibit_o | output | 1 | Holds off the time update |
| ctrl_o | output | 8 | Current control byte |
| flags_o | output | 3 | {PF, AF, UF} |

## Verification
The bench builds the block with RATE_W=4, which gives sixteen taps, and with a two-stage reset synchronizer. A tap pattern of 16'hA5A5 then lets it reach rate code 0 while tap 0 is high, together with codes that select a high tap and a low tap. With these settings every reset-rule combination can be hit: SET is held through the functional reset, a write is suppressed during reset, and an event lands in the same cycle as a flag read.

// File: rtl/rtc_ctrl_pkg.sv
package rtc_ctrl_pkg;
  localparam int CTRL_W = 8;
  localparam int B_SET  = 7;
  localparam int B_PIE  = 6;
  localparam int B_AIE  = 5;
  localparam int B_UIE  = 4;
  localparam int B_SQWE = 3;
  localparam int NUM_SRC = 3;
  localparam int SRC_UF = 0;
  localparam int SRC_AF = 1;
  localparam int SRC_PF = 2;
  localparam logic [CTRL_W-1:0] CTRL_PWRUP   = 8'h08;
  localparam logic [CTRL_W-1:0] RST_CLR_MASK = 8'h58;
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_in_n,
  output logic arst_out_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_in_n) begin
    if (!arst_in_n) sync_q <= '0;
    else            sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign arst_out_n = sync_q[STAGES-1];
endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              arst_n,
  input  logic              func_rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_en;

  assign ctrl_en = !func_rst_n || wr_en;

  always_comb begin
    ctrl_d = ctrl_q;
    if (!func_rst_n) begin
      ctrl_d = ctrl_q & ~RST_CLR_MASK;
    end else if (wr_en) begin
      ctrl_d = wdata;
      if (wdata[B_SET]) ctrl_d[B_UIE] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      ctrl_q <= CTRL_PWRUP;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  // R3: writing SET high leaves UIE cleared
  a_r3_set_clears_uie: assert property (@(posedge clk) disable iff (!arst_n)
    (wr_en && func_rst_n && wdata[B_SET]) |=> !ctrl_q[B_UIE]);
  // R4: functional reset clears its bits
  a_r4_reset_clears: assert property (@(posedge clk) disable iff (!arst_n)
    !func_rst_n |=> (!ctrl_q[B_PIE] && !ctrl_q[B_UIE] && !ctrl_q[B_SQWE]));
  // R4: functional reset keeps the host-owned bits
  a_r4_reset_keeps: assert property (@(posedge clk) disable iff (!arst_n)
    !func_rst_n |=> ((ctrl_q & ~RST_CLR_MASK) == ($past(ctrl_q) & ~RST_CLR_MASK)));
endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit
  import rtc_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               arst_n,
  input  logic               func_rst_n,
  input  logic               rd_clr,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic [NUM_SRC-1:0] flag_o,
  output logic               irq_any_o
);
  logic [NUM_SRC-1:0] flag_q, flag_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_comb begin
      if (!func_rst_n) flag_d[i] = 1'b0;
      else             flag_d[i] = (flag_q[i] && !rd_clr) || evt_i[i];
    end

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) flag_q[i] <= 1'b0;
      else         flag_q[i] <= flag_d[i];
    end

    // R5: an event always sets its flag
    a_r5_event_sets: assert property (@(posedge clk) disable iff (!arst_n)
      (evt_i[i] && func_rst_n) |=> flag_q[i]);
  end

  assign irq_any_o = |(flag_q & en_i);
  assign flag_o    = flag_q;

  // R7: a quiet read empties the flags
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!arst_n)
    (rd_clr && evt_i == '0) |=> (flag_q == '0));
  // R6: no enabled source means no interrupt
  a_r6_quiet_when_disabled: assert property (@(posedge clk) disable iff (!arst_n)
    (en_i == '0) |-> !irq_any_o);
endmodule

// File: rtl/rtc_sqw_gen.sv
module rtc_sqw_gen #(
  parameter int RATE_W = 4,
  localparam int NUM_TAPS = 2**RATE_W
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                en,
  input  logic [RATE_W-1:0]   rate_sel,
  input  logic [NUM_TAPS-1:0] taps,
  output logic                sqw_o
);
  logic sqw_q, sqw_d;

  always_comb begin
    sqw_d = en && (rate_sel != '0) && taps[rate_sel];
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sqw_q <= 1'b0;
    else         sqw_q <= sqw_d;
  end

  assign sqw_o = sqw_q;

  // R8: disabled output stays low
  a_r8_low_when_off: assert property (@(posedge clk) disable iff (!arst_n)
    !en |=> !sqw_q);
  // R8: rate code zero silences the output
  a_r8_rate_zero_low: assert property (@(posedge clk) disable iff (!arst_n)
    (rate_sel == '0) |=> !sqw_q);
endmodule

// File: rtl/rtc_ctrl_irq.sv
module rtc_ctrl_irq
  import rtc_ctrl_pkg::*;
#(
  parameter int RATE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    por_n,
  input  logic                    rst_n,
  input  logic                    cs,
  input  logic                    we,
  input  logic                    addr,
  input  logic [CTRL_W-1:0]       wdata,
  output logic [CTRL_W-1:0]       rdata,
  input  logic                    per_evt,
  input  logic                    alm_evt,
  input  logic                    upd_evt,
  input  logic [RATE_W-1:0]       rate_sel,
  input  logic [(2**RATE_W)-1:0]  rate_taps,
  output logic                    irq_n,
  output logic                    sqw_o,
  output logic                    upd_inhibit_o,
  output logic [CTRL_W-1:0]       ctrl_o,
  output logic [NUM_SRC-1:0]      flags_o
);
  logic               arst_n;
  logic               wr_ctrl, rd_any, rd_status;
  logic [CTRL_W-1:0]  ctrl, status, rdata_q, rdata_d;
  logic [NUM_SRC-1:0] evt, en, flags;
  logic               irq_any;

  rtc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .arst_in_n(por_n), .arst_out_n(arst_n)
  );

  assign wr_ctrl   = cs && we && !addr;
  assign rd_any    = cs && !we;
  assign rd_status = rd_any && addr;

  rtc_ctrl_reg u_ctrl (
    .clk(clk), .arst_n(arst_n), .func_rst_n(rst_n),
    .wr_en(wr_ctrl), .wdata(wdata), .ctrl_o(ctrl)
  );

  always_comb begin
    evt = '0;
    evt[SRC_PF] = per_evt;
    evt[SRC_AF] = alm_evt;
    evt[SRC_UF] = upd_evt;
    en = '0;
    en[SRC_PF] = ctrl[B_PIE];
    en[SRC_AF] = ctrl[B_AIE];
    en[SRC_UF] = ctrl[B_UIE];
  end

  rtc_flag_unit u_flags (
    .clk(clk), .arst_n(arst_n), .func_rst_n(rst_n), .rd_clr(rd_status),
    .evt_i(evt), .en_i(en), .flag_o(flags), .irq_any_o(irq_any)
  );

  rtc_sqw_gen #(.RATE_W(RATE_W)) u_sqw (
    .clk(clk), .arst_n(arst_n), .en(ctrl[B_SQWE]),
    .rate_sel(rate_sel), .taps(rate_taps), .sqw_o(sqw_o)
  );

  assign status = {irq_any, flags, {(CTRL_W-1-NUM_SRC){1'b0}}};

  always_comb begin
    rdata_d = addr ? status : ctrl;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     rdata_q <= '0;
    else if (rd_any) rdata_q <= rdata_d;
  end

  assign rdata         = rdata_q;
  assign irq_n         = !irq_any;
  assign upd_inhibit_o = ctrl[B_SET];
  assign ctrl_o        = ctrl;
  assign flags_o       = flags;

  // R9: inhibit only changes with a control write or never
  a_r9_inhibit_stable: assert property (@(posedge clk) disable iff (!arst_n)
    !wr_ctrl |=> $stable(upd_inhibit_o));
endmodule

// File: tb/tb_rtc_ctrl_irq.sv
module tb_rtc_ctrl_irq;
  logic        clk = 1'b0;
  logic        por_n, rst_n, cs, we, addr;
  logic [7:0]  wdata, rdata, ctrl_o;
  logic        per_evt, alm_evt, upd_evt;
  logic [3:0]  rate_sel;
  logic [15:0] rate_taps;
  logic        irq_n, sqw_o, upd_inhibit_o;
  logic [2:0]  flags_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  rtc_ctrl_irq #(.RATE_W(4), .SYNC_STAGES(2)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .per_evt(per_evt), .alm_evt(alm_evt),
    .upd_evt(upd_evt), .rate_sel(rate_sel), .rate_taps(rate_taps),
    .irq_n(irq_n), .sqw_o(sqw_o), .upd_inhibit_o(upd_inhibit_o),
    .ctrl_o(ctrl_o), .flags_o(flags_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: pops expected read data one cycle after each read strobe
  always @(posedge clk) begin
    if (cs === 1'b1 && we === 1'b0) begin
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, rdata, e.val);
      end
    end
  end

  task automatic host_write(input logic [7:0] d);
    @(negedge clk); cs = 1; we = 1; addr = 0; wdata = d;
    @(negedge clk); cs = 0; we = 0;
  endtask

  task automatic host_read(input logic a, input logic [7:0] expv, input string tag);
    exp_t e;
    e.val = expv; e.tag = tag;
    @(negedge clk); cs = 1; we = 0; addr = a; exp_q.push_back(e);
    @(negedge clk); cs = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 2) per_evt = 1; else if (which == 1) alm_evt = 1; else upd_evt = 1;
    @(negedge clk); per_evt = 0; alm_evt = 0; upd_evt = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    por_n = 0; rst_n = 1; cs = 0; we = 0; addr = 0; wdata = 0;
    per_evt = 0; alm_evt = 0; upd_evt = 0; rate_sel = 0; rate_taps = 16'hA5A5;
    repeat (4) @(negedge clk);
    por_n = 1;
    repeat (3) @(negedge clk);

    check("R1 ctrl", ctrl_o, 8'h08);
    check("R1 flags", {5'b0, flags_o}, 8'h00);
    check("R1 irq_n", {7'b0, irq_n}, 8'h01);
    check("R1 inhibit", {7'b0, upd_inhibit_o}, 8'h00);
    host_read(0, 8'h08, "R1 read ctrl");

    // R8 rate taps with SQWE set
    @(negedge clk); rate_sel = 4'd2; @(negedge clk);
    check("R8 tap2", {7'b0, sqw_o}, 8'h01);
    rate_sel = 4'd1; @(negedge clk);
    check("R8 tap1", {7'b0, sqw_o}, 8'h00);
    rate_sel = 4'd0; @(negedge clk);
    check("R8 rate0", {7'b0, sqw_o}, 8'h00);
    rate_sel = 4'd2;

    // R2 plain write and readback
    host_write(8'h77);
    check("R2 ctrl", ctrl_o, 8'h77);
    host_read(0, 8'h77, "R2 read ctrl");
    @(negedge clk);
    check("R8 sqwe off", {7'b0, sqw_o}, 8'h00);

    // R5 flag sets with enables off
    host_write(8'h07);
    pulse(2);
    check("R5 pf", {5'b0, flags_o}, 8'h04);
    check("R6 irq masked", {7'b0, irq_n}, 8'h01);
    host_read(1, 8'h40, "R7 status pf");
    check("R7 cleared", {5'b0, flags_o}, 8'h00);

    // R6 periodic enabled
    host_write(8'h47);
    pulse(2);
    check("R6 pie irq", {7'b0, irq_n}, 8'h00);
    host_read(1, 8'hC0, "R7 status irqf");
    check("R6 irq released", {7'b0, irq_n}, 8'h01);

    // R6 alarm enabled
    host_write(8'h27);
    pulse(1);
    check("R5 af", {5'b0, flags_o}, 8'h02);
    check("R6 aie irq", {7'b0, irq_n}, 8'h00);
    host_read(1, 8'hA0, "R7 status af");

    // R6 enable after flag
    host_write(8'h07);
    pulse(0);
    check("R5 uf", {5'b0, flags_o}, 8'h01);
    check("R6 uie off", {7'b0, irq_n}, 8'h01);
    host_write(8'h17);
    check("R6 uie on", {7'b0, irq_n}, 8'h00);
    host_read(1, 8'h90, "R7 status uf");

    // R7 event in read cycle is kept
    @(negedge clk); cs = 1; we = 0; addr = 1; per_evt = 1;
    begin exp_t e; e.val = 8'h00; e.tag = "R7 read during event"; exp_q.push_back(e); end
    @(negedge clk); cs = 0; per_evt = 0;
    check("R7 event kept", {5'b0, flags_o}, 8'h04);
    host_read(1, 8'h40, "R7 second read");

    // R3 SET write clears UIE
    host_write(8'h9F);
    check("R3 ctrl", ctrl_o, 8'h8F);
    check("R9 inhibit on", {7'b0, upd_inhibit_o}, 8'h01);
    host_read(0, 8'h8F, "R3 read ctrl");

    // R4 functional reset with concurrent write
    host_write(8'hFF);
    check("R3 ctrl ff", ctrl_o, 8'hEF);
    pulse(0);
    @(negedge clk); rst_n = 0; cs = 1; we = 1; addr = 0; wdata = 8'h00;
    @(negedge clk); rst_n = 1; cs = 0; we = 0;
    check("R4 ctrl", ctrl_o, 8'hA7);
    check("R4 flags", {5'b0, flags_o}, 8'h00);
    @(negedge clk);
    check("R4 sqw", {7'b0, sqw_o}, 8'h00);

    host_write(8'h27);
    check("R9 inhibit off", {7'b0, upd_inhibit_o}, 8'h00);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule